// File: doc/BRIEF.md
# Display Frame Fetch Sequencer

This block generates the memory read requests that feed pixel and palette words to a raster display pipeline. Software sets up two address windows, each as a start word address and an inclusive last word address. It also picks a load mode. The sequencer then walks the chosen window one word at a time over a valid/ready request port.

In continuous modes, a new frame starts in the cycle right after the last word of the previous frame is accepted. When the two-window option is on, successive frames alternate between window 0 and window 1. This lets software reprogram whichever window is idle while the other one is being read.

Frame ends, palette completion and two error events from the display pipeline are recorded in a sticky status register. Software clears a status bit by writing a 1 to it. A single interrupt line is raised when any status bit is set and its enable is set.

Top module: `frame_fetch_seq`

## Requirements
- R1: The register port is word-aligned with byte offsets, and reads are combinational.
  - 0x30: raster control. Bit 0 is the engine enable, bit 4 is the palette interrupt enable, bit 6 is the error interrupt enable, and bits 21:20 are the load mode.
  - 0x34: status.
  - 0x40: DMA control. Bit 0 turns on two-window alternation and bit 1 is the end-of-frame interrupt enable.
  - 0x44: start address of window 0. 0x48: last address of window 0.
  - 0x4C: start address of window 1. 0x50: last address of window 1.
  - Unused bits read as 0, and every register resets to 0.
- R2: A frame issues every word address from the start address up to and including the last address, in increasing order. The address advances only on an accepted handshake. While `rq_ready` is low, the request stays valid and its address does not change.
- R3: Load mode 10 (data only) fetches frames back to back. With two-window alternation off, every frame uses window 0. Status bit 8 is set when the last word of a window-0 frame is accepted.
- R4: With two-window alternation on, frames alternate between window 0 and window 1, starting with window 0. Status bit 9 is set when the last word of a window-1 frame is accepted. Reprogramming the idle window takes effect on that window's next frame.
- R5: Load mode 00 (palette then data) fetches frames like R3/R4. In every frame, status bit 6 is set when word number PAL_WORDS is accepted, counting from 1, and fetching goes on to the last address.
- R6: Load mode 01 (palette only) fetches window 0 once and then sets status bit 6. It does not set bits 8 or 9. It issues no further request until the engine enable is cleared.
- R7: The window addresses and the load mode are captured at the start of each frame. Rewriting them while a frame is in progress leaves that frame's addresses unchanged.
- R8: Writing a 1 to a status bit clears it, and writing a 0 has no effect. If a bit is set by an event in the same cycle that it is cleared, it ends up set.
- R9: A high cycle on `underflow_evt` sets status bit 5, and a high cycle on `sync_lost_evt` sets status bit 2.
- R10: `irq` is high exactly when one of these holds:
  - status bit 8 or bit 9 is set and the end-of-frame interrupt enable is set;
  - bit 6 is set and the palette interrupt enable is set;
  - bit 5 or bit 2 is set and the error interrupt enable is set.
- R11: When the engine enable is cleared during a fetch, the pending request is held until it is accepted. The sequencer then goes idle, and the next enable starts from window 0.
- R12: Load mode 11 behaves exactly like load mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| rq_valid | output | 1 | Read request valid |
| rq_addr | output | ADDR_W | Read request word address |
| rq_ready | input | 1 | Read request accepted by the fabric |
| underflow_evt | input | 1 | FIFO underflow event pulse |
| sync_lost_evt | input | 1 | Sync lost event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
Two events can land in the same cycle:
- A frame's last word is accepted while software writes a 1 to the end-of-frame bit that this acceptance sets. The bench provokes this by forcing `rq_ready` high on the last word and driving the status write in that same cycle. It judges the result by reading the bit back, which must still be set.
- A register rewrite lands while that window is being fetched. The bench drives a write to the last-address register in the middle of a frame and at the first word of the other window. The current frame must end at its old boundary, and only the next use of that window may follow the new value.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_RASTER = 8'h30;
  localparam logic [7:0] OFS_STATUS = 8'h34;
  localparam logic [7:0] OFS_DMACTL = 8'h40;
  localparam logic [7:0] OFS_PAIR0  = 8'h44;  // start of window 0; last at +4
  localparam int         PAIR_STEP  = 8;      // window 1 sits one step above

  // raster control fields
  localparam int RC_EN     = 0;
  localparam int RC_PALIE  = 4;
  localparam int RC_ERRIE  = 6;
  localparam int RC_MODE_L = 20;

  // dma control fields
  localparam int DC_DUAL  = 0;
  localparam int DC_EOFIE = 1;

  // status bits
  localparam int ST_W     = 10;
  localparam int ST_SYNC  = 2;
  localparam int ST_UNDER = 5;
  localparam int ST_PAL   = 6;
  localparam int ST_EOF0  = 8;
  localparam int ST_EOF1  = 9;

  typedef enum logic [1:0] {
    LM_PAL_DATA = 2'b00,
    LM_PAL_ONLY = 2'b01,
    LM_DATA     = 2'b10,
    LM_RSVD     = 2'b11
  } load_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_HALT
  } sq_state_e;

  // sticky bits: an event set wins over a same-cycle clear
  function automatic logic [ST_W-1:0] w1c_next(input logic [ST_W-1:0] cur,
                                               input logic [ST_W-1:0] set,
                                               input logic [ST_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // window used by the frame that follows one on window cur
  function automatic logic next_pair(input logic cur, input logic dual);
    return dual ? ~cur : 1'b0;
  endfunction

  // palette-complete event for an accepted word at index idx
  function automatic logic pal_event(input load_mode_e m, input logic [31:0] idx,
                                     input logic last, input int unsigned palw);
    return ((m == LM_PAL_ONLY) && last) ||
           ((m == LM_PAL_DATA) && (idx == palw - 1));
  endfunction

endpackage

// File: rtl/ffs_regs.sv
module ffs_regs
  import ffs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  input  logic [ST_W-1:0]   status,
  output logic [31:0]       rd_data,
  output logic              eng_en,
  output logic              pal_ie,
  output logic              err_ie,
  output load_mode_e        mode,
  output logic              dual_en,
  output logic              eof_ie,
  output logic [ADDR_W-1:0] base0,
  output logic [ADDR_W-1:0] ceil0,
  output logic [ADDR_W-1:0] base1,
  output logic [ADDR_W-1:0] ceil1,
  output logic [ST_W-1:0]   stat_clr
);

  logic [ADDR_W-1:0] base_q [2];
  logic [ADDR_W-1:0] ceil_q [2];
  logic              unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_en  <= 1'b0;
      pal_ie  <= 1'b0;
      err_ie  <= 1'b0;
      mode    <= LM_PAL_DATA;
      dual_en <= 1'b0;
      eof_ie  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == OFS_RASTER) begin
        eng_en <= wr_data[RC_EN];
        pal_ie <= wr_data[RC_PALIE];
        err_ie <= wr_data[RC_ERRIE];
        mode   <= load_mode_e'(wr_data[RC_MODE_L+1:RC_MODE_L]);
      end
      if (wr_addr == OFS_DMACTL) begin
        dual_en <= wr_data[DC_DUAL];
        eof_ie  <= wr_data[DC_EOFIE];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    localparam logic [7:0] OFS_B = OFS_PAIR0 + 8'(p * PAIR_STEP);
    localparam logic [7:0] OFS_C = OFS_B + 8'd4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[p] <= '0;
        ceil_q[p] <= '0;
      end else if (wr_en) begin
        if (wr_addr == OFS_B) base_q[p] <= wr_data[ADDR_W-1:0];
        if (wr_addr == OFS_C) ceil_q[p] <= wr_data[ADDR_W-1:0];
      end
    end
  end

  assign base0 = base_q[0];
  assign ceil0 = ceil_q[0];
  assign base1 = base_q[1];
  assign ceil1 = ceil_q[1];

  assign stat_clr = (wr_en && wr_addr == OFS_STATUS) ? wr_data[ST_W-1:0] : '0;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_RASTER: begin
        rd_data[RC_EN]                 = eng_en;
        rd_data[RC_PALIE]              = pal_ie;
        rd_data[RC_ERRIE]              = err_ie;
        rd_data[RC_MODE_L+1:RC_MODE_L] = mode;
      end
      OFS_STATUS: rd_data[ST_W-1:0] = status;
      OFS_DMACTL: begin
        rd_data[DC_DUAL]  = dual_en;
        rd_data[DC_EOFIE] = eof_ie;
      end
      OFS_PAIR0:                        rd_data = 32'(base_q[0]);
      OFS_PAIR0 + 8'd4:                 rd_data = 32'(ceil_q[0]);
      OFS_PAIR0 + 8'(PAIR_STEP):        rd_data = 32'(base_q[1]);
      OFS_PAIR0 + 8'(PAIR_STEP) + 8'd4: rd_data = 32'(ceil_q[1]);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ffs_status.sv
module ffs_status
  import ffs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr_vec,
  input  logic [ST_W-1:0] ie_vec,
  output logic [ST_W-1:0] status,
  output logic            irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= w1c_next(status, set_vec, clr_vec);
  end

  assign irq = |(status & ie_vec);

  // a bit only drops when software wrote 1 to it
  assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status) & ~$past(clr_vec)) == '0));

  // an event always leaves its bit set, even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // a bit only rises from an event
  assert_rise_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/ffs_seq.sv
module ffs_seq
  import ffs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAL_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_en,
  input  load_mode_e        mode,
  input  logic              dual_en,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] ceil0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] ceil1,
  output logic              rq_valid,
  output logic [ADDR_W-1:0] rq_addr,
  input  logic              rq_ready,
  output logic              ev_eof0,
  output logic              ev_eof1,
  output logic              ev_pal
);

  sq_state_e         state;
  logic              pair_q;
  load_mode_e        wmode;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] wceil;
  logic [ADDR_W-1:0] widx;

  // named internal events
  logic accept;
  logic last_word;
  logic frame_done;
  logic pair_nxt;

  assign rq_valid   = (state == SQ_FETCH);
  assign rq_addr    = waddr;
  assign accept     = rq_valid && rq_ready;
  assign last_word  = (waddr == wceil);
  assign frame_done = accept && last_word && (wmode != LM_PAL_ONLY);
  assign pair_nxt   = next_pair(pair_q, dual_en);

  assign ev_eof0 = frame_done && !pair_q;
  assign ev_eof1 = frame_done &&  pair_q;
  assign ev_pal  = accept && pal_event(wmode, 32'(widx), last_word, PAL_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      pair_q <= 1'b0;
      wmode  <= LM_PAL_DATA;
      waddr  <= '0;
      wceil  <= '0;
      widx   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (eng_en) begin
            state  <= SQ_FETCH;
            pair_q <= 1'b0;
            waddr  <= base0;
            wceil  <= ceil0;
            widx   <= '0;
            wmode  <= mode;
          end
        end
        SQ_FETCH: begin
          if (accept) begin
            if (!eng_en) begin
              state  <= SQ_IDLE;
              pair_q <= 1'b0;
            end else if (last_word) begin
              if (wmode == LM_PAL_ONLY) begin
                state <= SQ_HALT;
              end else begin
                pair_q <= pair_nxt;
                waddr  <= pair_nxt ? base1 : base0;
                wceil  <= pair_nxt ? ceil1 : ceil0;
                widx   <= '0;
                wmode  <= mode;
              end
            end else begin
              waddr <= waddr + 1'b1;
              widx  <= widx + 1'b1;
            end
          end
        end
        SQ_HALT: begin
          if (!eng_en) begin
            state  <= SQ_IDLE;
            pair_q <= 1'b0;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_addr)));

  assert_within_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> (rq_addr <= wceil));

  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eof0 && dual_en && eng_en) |=> (rq_valid && rq_addr == $past(base1)));

  assert_pal_only_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pal && wmode == LM_PAL_ONLY) |=> !rq_valid);

  assert_stop_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && !eng_en) |-> !rq_valid);

  assert_idle_pair0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE) |-> !pair_q);

endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq
  import ffs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAL_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              rq_valid,
  output logic [ADDR_W-1:0] rq_addr,
  input  logic              rq_ready,
  input  logic              underflow_evt,
  input  logic              sync_lost_evt,
  output logic              irq
);

  logic              eng_en, pal_ie, err_ie, dual_en, eof_ie;
  load_mode_e        mode;
  logic [ADDR_W-1:0] base0, ceil0, base1, ceil1;
  logic [ST_W-1:0]   status, stat_clr, set_vec, ie_vec;
  logic              ev_eof0, ev_eof1, ev_pal;

  ffs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status(status), .rd_data(rd_data),
    .eng_en(eng_en), .pal_ie(pal_ie), .err_ie(err_ie), .mode(mode),
    .dual_en(dual_en), .eof_ie(eof_ie),
    .base0(base0), .ceil0(ceil0), .base1(base1), .ceil1(ceil1),
    .stat_clr(stat_clr)
  );

  ffs_seq #(.ADDR_W(ADDR_W), .PAL_WORDS(PAL_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .mode(mode), .dual_en(dual_en),
    .base0(base0), .ceil0(ceil0), .base1(base1), .ceil1(ceil1),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_ready(rq_ready),
    .ev_eof0(ev_eof0), .ev_eof1(ev_eof1), .ev_pal(ev_pal)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[ST_EOF0]  = ev_eof0;
    set_vec[ST_EOF1]  = ev_eof1;
    set_vec[ST_PAL]   = ev_pal;
    set_vec[ST_UNDER] = underflow_evt;
    set_vec[ST_SYNC]  = sync_lost_evt;
    ie_vec            = '0;
    ie_vec[ST_EOF0]   = eof_ie;
    ie_vec[ST_EOF1]   = eof_ie;
    ie_vec[ST_PAL]    = pal_ie;
    ie_vec[ST_UNDER]  = err_ie;
    ie_vec[ST_SYNC]   = err_ie;
  end

  ffs_status u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(stat_clr),
    .ie_vec(ie_vec), .status(status), .irq(irq)
  );

endmodule

// File: tb/frame_fetch_seq_tb.sv
module frame_fetch_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int PALW       = 4;
  localparam int WATCHDOG   = 50000;

  localparam logic [7:0] A_RC = 8'h30, A_ST = 8'h34, A_DC = 8'h40;
  localparam logic [7:0] A_B0 = 8'h44, A_C0 = 8'h48, A_B1 = 8'h4C, A_C1 = 8'h50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = A_ST;
  logic [31:0]   rd_data;
  logic          rq_valid;
  logic [AW-1:0] rq_addr;
  logic          rq_ready = 1'b0;
  logic          underflow_evt = 1'b0;
  logic          sync_lost_evt = 1'b0;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_fetch_seq #(.ADDR_W(AW), .PAL_WORDS(PALW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rq_valid(rq_valid), .rq_addr(rq_addr),
    .rq_ready(rq_ready), .underflow_evt(underflow_evt), .sync_lost_evt(sync_lost_evt),
    .irq(irq)
  );

  function automatic logic [31:0] rc(input logic [1:0] m, input bit en,
                                     input bit palie, input bit errie);
    return (32'(m) << 20) | (32'(errie) << 6) | (32'(palie) << 4) | 32'(en);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
    rd_addr = A_ST;
    #1;
  endtask

  // Fetch one frame of n words from base; optional register write while word
  // wr_idx is presented (ready forced high in that cycle).
  task automatic frame(input string req, input logic [AW-1:0] base, input int n,
                       input int stall, input int wr_idx, input logic [7:0] wa,
                       input logic [31:0] wd, input bit chkpal);
    int idx = 0;
    int c = 0;
    int w = 0;
    while (!rq_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    while (idx < n && c < 400) begin
      @(negedge clk);
      if (chkpal) check("R5 palette flag", 32'(rd_data[6]), 32'(idx >= PALW));
      if (idx == wr_idx) begin
        rq_ready = 1'b1;
        wr_en = 1'b1; wr_addr = wa; wr_data = wd;
      end else begin
        wr_en = 1'b0;
        case (stall)
          0:       rq_ready = 1'b1;
          1:       rq_ready = (c % 2) == 1;
          default: rq_ready = (c % 3) == 2;
        endcase
      end
      check({req, " R2 request"}, {19'b0, rq_valid, rq_addr}, {19'b0, 1'b1, base + AW'(idx)});
      @(posedge clk);
      if (rq_ready) idx++;
      c++;
    end
    @(negedge clk);
    rq_ready = 1'b0;
    wr_en = 1'b0;
    if (chkpal) check("R5 palette flag end", 32'(rd_data[6]), 32'(n >= PALW));
  endtask

  // clear enable with a request pending (R11)
  task automatic stop_eng(input logic [31:0] rc_off, input logic [AW-1:0] pend);
    @(negedge clk);
    rq_ready = 1'b0;
    wr_en = 1'b1; wr_addr = A_RC; wr_data = rc_off;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 held after disable", {19'b0, rq_valid, rq_addr}, {19'b0, 1'b1, pend});
    @(negedge clk);
    check("R11 still held", {19'b0, rq_valid, rq_addr}, {19'b0, 1'b1, pend});
    rq_ready = 1'b1;
    @(negedge clk);
    rq_ready = 1'b0;
    check("R11 idle after accept", 32'(rq_valid), 32'd0);
    @(negedge clk);
    check("R11 stays idle", 32'(rq_valid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1)
    check("R1 reset rq_valid", 32'(rq_valid), 0);
    check("R1 reset irq", 32'(irq), 0);
    rdreg(A_ST, d); check("R1 reset status", d, 0);
    rdreg(A_RC, d); check("R1 reset raster", d, 0);
    rdreg(A_C1, d); check("R1 reset last1", d, 0);

    // register readback (R1)
    wr(A_B0, 32'hFFFF_F123); rdreg(A_B0, d); check("R1 start0", d, 32'h123);
    wr(A_C0, 32'h0000_0456); rdreg(A_C0, d); check("R1 last0", d, 32'h456);
    wr(A_B1, 32'h0000_0789); rdreg(A_B1, d); check("R1 start1", d, 32'h789);
    wr(A_C1, 32'h0000_0ABC); rdreg(A_C1, d); check("R1 last1", d, 32'hABC);
    wr(A_DC, 32'hFFFF_FFFF); rdreg(A_DC, d); check("R1 dma ctrl", d, 32'h3);
    wr(A_RC, 32'hFFFF_FFFE); rdreg(A_RC, d); check("R1 raster", d, 32'h0030_0050);
    wr(A_RC, 0); wr(A_DC, 0);

    // R3/R2 sweep: sizes x stall patterns, data-only, single window
    for (int n = 1; n <= 4; n++) begin
      for (int s = 0; s < 3; s++) begin
        logic [AW-1:0] b;
        b = AW'(12'h100 + n * 16 + s * 4);
        wr(A_B0, 32'(b)); wr(A_C0, 32'(b + AW'(n - 1)));
        wr(A_ST, 32'h3FF);
        wr(A_RC, rc(2'b10, 1, 0, 0));
        frame("R3 f1", b, n, s, -1, 0, 0, 0);
        rdreg(A_ST, d); check("R3 eof0 set, eof1 clear", d & 32'h300, 32'h100);
        frame("R3 f2 same window", b, n, s, -1, 0, 0, 0);
        stop_eng(rc(2'b10, 0, 0, 0), b);
      end
    end

    // R8 collision: clear of bit 8 in the cycle the last word sets it
    wr(A_B0, 32'h200); wr(A_C0, 32'h202);
    wr(A_ST, 32'h3FF);
    rdreg(A_ST, d); check("R8 cleared before", d, 0);
    wr(A_RC, rc(2'b10, 1, 0, 0));
    frame("R8 collide", 12'h200, 3, 0, 2, A_ST, 32'h100, 0);
    rdreg(A_ST, d); check("R8 set wins over clear", d & 32'h100, 32'h100);
    stop_eng(rc(2'b10, 0, 0, 0), 12'h200);
    wr(A_ST, 0); rdreg(A_ST, d); check("R8 write 0 no effect", d & 32'h100, 32'h100);
    wr(A_ST, 32'h100); rdreg(A_ST, d); check("R8 write 1 clears", d, 0);

    // R7: mid-frame rewrite of last address applies to next frame only
    wr(A_B0, 32'h300); wr(A_C0, 32'h305);
    wr(A_RC, rc(2'b10, 1, 0, 0));
    frame("R7 current frame unchanged", 12'h300, 6, 0, 1, A_C0, 32'h302, 0);
    frame("R7 next frame new last", 12'h300, 3, 1, -1, 0, 0, 0);
    stop_eng(rc(2'b10, 0, 0, 0), 12'h300);

    // R4 dual window alternation, idle window reload, R11 restart at window 0
    wr(A_DC, 32'h1);
    wr(A_B0, 32'h400); wr(A_C0, 32'h402);
    wr(A_B1, 32'h480); wr(A_C1, 32'h481);
    wr(A_ST, 32'h3FF);
    wr(A_RC, rc(2'b10, 1, 0, 0));
    frame("R4 w0", 12'h400, 3, 0, -1, 0, 0, 0);
    rdreg(A_ST, d); check("R4 eof0 only", d & 32'h300, 32'h100);
    frame("R4 w1", 12'h480, 2, 2, -1, 0, 0, 0);
    rdreg(A_ST, d); check("R4 eof1 set", d & 32'h200, 32'h200);
    frame("R4 w0 with w1 reload", 12'h400, 3, 1, 0, A_C1, 32'h483, 0);
    frame("R4 w1 reloaded", 12'h480, 4, 0, -1, 0, 0, 0);
    frame("R4 w0 again", 12'h400, 3, 0, -1, 0, 0, 0);
    stop_eng(rc(2'b10, 0, 0, 0), 12'h480);
    wr(A_RC, rc(2'b10, 1, 0, 0));
    frame("R11 restart from window 0", 12'h400, 3, 0, -1, 0, 0, 0);
    stop_eng(rc(2'b10, 0, 0, 0), 12'h480);
    wr(A_DC, 0);

    // R5 palette+data with palette interrupt (R10)
    wr(A_B0, 32'h500); wr(A_C0, 32'h507);
    wr(A_ST, 32'h3FF);
    wr(A_RC, rc(2'b00, 1, 1, 0));
    frame("R5 pal+data", 12'h500, 8, 0, -1, 0, 0, 1);
    rdreg(A_ST, d); check("R5 eof0 after full frame", d & 32'h140, 32'h140);
    check("R10 irq from palette enable", 32'(irq), 1);
    stop_eng(rc(2'b00, 0, 1, 0), 12'h500);
    wr(A_RC, 0);
    check("R10 irq off with enables off", 32'(irq), 0);

    // R6 palette only
    wr(A_B0, 32'h600); wr(A_C0, 32'h602);
    wr(A_ST, 32'h3FF);
    wr(A_RC, rc(2'b01, 1, 0, 0));
    frame("R6 pal only", 12'h600, 3, 1, -1, 0, 0, 0);
    begin
      int extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (rq_valid) extra++;
      end
      check("R6 no further requests", 32'(extra), 0);
    end
    rdreg(A_ST, d); check("R6 pal done, no eof", d & 32'h340, 32'h040);
    wr(A_RC, 0);
    @(negedge clk);

    // R12 mode 11 acts as data only
    wr(A_ST, 32'h3FF);
    wr(A_RC, rc(2'b11, 1, 0, 0));
    frame("R12 f1", 12'h600, 3, 0, -1, 0, 0, 0);
    frame("R12 f2", 12'h600, 3, 2, -1, 0, 0, 0);
    rdreg(A_ST, d); check("R12 eof0, no pal", d & 32'h340, 32'h100);
    stop_eng(rc(2'b11, 0, 0, 0), 12'h600);

    // R10 end-of-frame enable
    wr(A_RC, 0);
    check("R10 eof pending, enable off", 32'(irq), 0);
    wr(A_DC, 32'h2);
    check("R10 eof enable raises irq", 32'(irq), 1);
    wr(A_ST, 32'h100);
    check("R10 irq drops after clear", 32'(irq), 0);
    wr(A_DC, 0);

    // R9 error events
    wr(A_ST, 32'h3FF);
    @(negedge clk); underflow_evt = 1'b1;
    @(negedge clk); underflow_evt = 1'b0;
    rdreg(A_ST, d); check("R9 underflow bit 5", d, 32'h020);
    check("R10 no irq without err enable", 32'(irq), 0);
    @(negedge clk); sync_lost_evt = 1'b1;
    @(negedge clk); sync_lost_evt = 1'b0;
    rdreg(A_ST, d); check("R9 sync lost bit 2", d, 32'h024);
    wr(A_RC, rc(2'b00, 0, 0, 1));
    check("R10 err enable raises irq", 32'(irq), 1);
    wr(A_ST, 32'h020);
    check("R10 irq held by sync bit", 32'(irq), 1);
    wr(A_ST, 32'h004);
    check("R10 irq clear", 32'(irq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule